// File: doc/BRIEF.md
# Byte-Halfword Memory Access Adapter

This block sits between a processor load/store port and a main store that moves exactly 16 bits per access, over a 16-bit byte address space (65,536 bytes). The requester asks for a byte, halfword or fullword, and the adapter turns that into one or two halfword store cycles.

A byte read fetches the containing halfword and returns the selected lane zero-extended. A byte write is a read-modify-write: the halfword is read, only the addressed lane is replaced, and the result is written back. A fullword is two halfword cycles, base address first, then base+2. Requests that break the alignment rules are refused with a fault pulse and never reach the store.

The controller is one enumerated state machine. Its states are ST_IDLE, ST_FAULT, ST_RD_FIRST, ST_RD_SECOND, ST_RD_LAST, ST_RESP, ST_WR_FIRST, ST_WR_SECOND, ST_RMW_READ, ST_RMW_WRITE and ST_DONE. Its transitions are as follows. ST_IDLE goes to ST_FAULT on a misaligned request, to ST_RD_FIRST on any read, to ST_RMW_READ on a byte write and to ST_WR_FIRST on a halfword or fullword write. ST_RD_FIRST goes to ST_RD_SECOND for a fullword and otherwise to ST_RD_LAST. ST_RD_SECOND goes to ST_RD_LAST, and ST_RD_LAST goes to ST_RESP. ST_WR_FIRST goes to ST_WR_SECOND for a fullword and otherwise to ST_DONE. ST_WR_SECOND goes to ST_DONE. ST_RMW_READ goes to ST_RMW_WRITE, and ST_RMW_WRITE goes to ST_DONE. ST_FAULT, ST_RESP and ST_DONE each return to ST_IDLE.

Top module: `memadapt_top`

## Requirements
- R1: While reset is held and in the first cycle after it, req_ready, rsp_valid, align_fault, mem_en and mem_we are all 0.
- R2: A byte read (req_size 2'b00) is legal at any address. It makes one store read of halfword index addr[15:1]. It returns bits [7:0] of that halfword when addr[0] is 0 and bits [15:8] when addr[0] is 1, in rsp_data[7:0], with rsp_data[31:8] zero.
- R3: A byte write (req_size 2'b00) takes exactly two store cycles at the same halfword index. The first is a read (mem_we 0) and the second is a write. The write replaces only the lane picked by addr[0] with req_wdata[7:0] and keeps the other lane.
- R4: A halfword access (req_size 2'b01) at an even address makes one store cycle. A read returns the halfword in rsp_data[15:0] with rsp_data[31:16] zero. A write stores req_wdata[15:0].
- R5: A fullword access (req_size 2'b10) with addr[1:0]==0 makes two store cycles, at index addr[15:1] first and at that index plus one second. Data bits [15:0] belong to the base address and bits [31:16] to base+2.
- R6: A request is misaligned when it is a halfword with addr[0]=1, a fullword with addr[1:0]!=0, or uses the reserved size 2'b11. It raises align_fault for one cycle together with req_ready. It makes no store cycle and raises no rsp_valid.
- R7: req_ready is a one-cycle pulse marking the end of a request. For a read, rsp_valid pulses in that same cycle with the data. The requester holds its request until req_ready.
- R8: Store read data is taken from mem_rdata in the cycle after the read cycle (one-cycle synchronous store).
- R9: mem_we is only ever asserted together with mem_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held until req_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 halfword, 10 fullword, 11 reserved |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 32 | Write data, low bits used for narrow sizes |
| req_ready | output | 1 | Request finished (one-cycle pulse) |
| rsp_valid | output | 1 | Read data valid (one-cycle pulse) |
| rsp_data | output | 32 | Read data, zero-extended |
| align_fault | output | 1 | Misaligned request refused (one-cycle pulse) |
| mem_en | output | 1 | Store cycle enable |
| mem_we | output | 1 | Store write enable |
| mem_addr | output | 15 | Halfword index |
| mem_wdata | output | 16 | Halfword written to the store |
| mem_rdata | input | 16 | Halfword read, valid the cycle after a read |

## Verification
The assertions take two things for granted. First, the requester keeps req_valid and every request field steady until the req_ready pulse. Second, the store returns the addressed halfword exactly one cycle after a read. The stimulus drives all requests from one task that raises req_valid on a falling edge and holds it through the completion pulse, then drops it. The bench's store model answers with the one-cycle latency. Fault cases use the same handshake, so a refused request never leaves the requester waiting.

// File: rtl/memadapt_pkg.sv
package memadapt_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_FULL = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FAULT,
        ST_RD_FIRST,
        ST_RD_SECOND,
        ST_RD_LAST,
        ST_RESP,
        ST_WR_FIRST,
        ST_WR_SECOND,
        ST_RMW_READ,
        ST_RMW_WRITE,
        ST_DONE
    } adapt_state_e;

endpackage

// File: rtl/memadapt_align.sv
module memadapt_align
    import memadapt_pkg::*;
(
    input  logic [1:0] size,
    input  logic [1:0] addr_lo,
    output logic       misaligned
);

    always_comb begin
        unique case (acc_size_e'(size))
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = addr_lo[0];
            SZ_FULL: misaligned = |addr_lo;
            default: misaligned = 1'b1;
        endcase
    end

endmodule

// File: rtl/memadapt_lane.sv
module memadapt_lane #(
    parameter int HW_W = 16
) (
    input  logic [HW_W-1:0]                                hw_in,
    input  logic [((HW_W/8) > 1 ? $clog2(HW_W/8) : 1)-1:0] lane_sel,
    input  logic [7:0]                                     new_byte,
    output logic [7:0]                                     byte_out,
    output logic [HW_W-1:0]                                merged
);

    localparam int LANES = HW_W / 8;
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [7:0] lane_bytes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bytes[g] = hw_in[g*8 +: 8];
        assign merged[g*8 +: 8] = (lane_sel == SEL_W'(g)) ? new_byte : hw_in[g*8 +: 8];
    end

    always_comb begin
        byte_out = 8'h00;
        for (int i = 0; i < LANES; i++) begin
            if (lane_sel == SEL_W'(i)) begin
                byte_out = lane_bytes[i];
            end
        end
    end

endmodule

// File: rtl/memadapt_ctrl.sv
module memadapt_ctrl
    import memadapt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int HW_W   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [1:0]           req_size,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [2*HW_W-1:0]    req_wdata,
    input  logic                 misaligned,
    input  logic [7:0]           byte_rd,
    input  logic [HW_W-1:0]      merged_hw,
    input  logic [HW_W-1:0]      mem_rdata,
    output logic                 lane_sel,
    output logic [7:0]           new_byte,
    output logic                 req_ready,
    output logic                 rsp_valid,
    output logic [2*HW_W-1:0]    rsp_data,
    output logic                 align_fault,
    output logic                 mem_en,
    output logic                 mem_we,
    output logic [ADDR_W-2:0]    mem_addr,
    output logic [HW_W-1:0]      mem_wdata
);

    localparam int DATA_W = 2 * HW_W;
    localparam int MEM_AW = ADDR_W - 1;

    adapt_state_e          state, state_n;
    logic [ADDR_W-1:0]     addr_q;
    acc_size_e             size_q;
    logic [DATA_W-1:0]     wdata_q;
    logic [DATA_W-1:0]     data_q;
    logic [MEM_AW-1:0]     base_idx;
    logic                  second_half;

    assign base_idx = addr_q[ADDR_W-1:1];
    assign lane_sel = addr_q[0];
    assign new_byte = wdata_q[7:0];

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (misaligned)                               state_n = ST_FAULT;
                    else if (!req_write)                          state_n = ST_RD_FIRST;
                    else if (acc_size_e'(req_size) == SZ_BYTE)    state_n = ST_RMW_READ;
                    else                                          state_n = ST_WR_FIRST;
                end
            end
            ST_FAULT:     state_n = ST_IDLE;
            ST_RD_FIRST:  state_n = (size_q == SZ_FULL) ? ST_RD_SECOND : ST_RD_LAST;
            ST_RD_SECOND: state_n = ST_RD_LAST;
            ST_RD_LAST:   state_n = ST_RESP;
            ST_RESP:      state_n = ST_IDLE;
            ST_WR_FIRST:  state_n = (size_q == SZ_FULL) ? ST_WR_SECOND : ST_DONE;
            ST_WR_SECOND: state_n = ST_DONE;
            ST_RMW_READ:  state_n = ST_RMW_WRITE;
            ST_RMW_WRITE: state_n = ST_DONE;
            ST_DONE:      state_n = ST_IDLE;
            default:      state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // request capture and read data assembly
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            size_q  <= SZ_BYTE;
            wdata_q <= '0;
            data_q  <= '0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                addr_q  <= req_addr;
                size_q  <= acc_size_e'(req_size);
                wdata_q <= req_wdata;
            end
            if (state == ST_RD_SECOND) begin
                data_q[HW_W-1:0] <= mem_rdata;
            end
            if (state == ST_RD_LAST) begin
                if (size_q == SZ_FULL) begin
                    data_q[DATA_W-1:HW_W] <= mem_rdata;
                end else if (size_q == SZ_HALF) begin
                    data_q <= DATA_W'(mem_rdata);
                end else begin
                    data_q <= DATA_W'(byte_rd);
                end
            end
        end
    end

    // outputs
    always_comb begin
        req_ready   = 1'b0;
        rsp_valid   = 1'b0;
        align_fault = 1'b0;
        mem_en      = 1'b0;
        mem_we      = 1'b0;
        second_half = 1'b0;
        mem_wdata   = '0;
        unique case (state)
            ST_FAULT: begin
                align_fault = 1'b1;
                req_ready   = 1'b1;
            end
            ST_RD_FIRST: begin
                mem_en = 1'b1;
            end
            ST_RD_SECOND: begin
                mem_en      = 1'b1;
                second_half = 1'b1;
            end
            ST_RESP: begin
                rsp_valid = 1'b1;
                req_ready = 1'b1;
            end
            ST_WR_FIRST: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = wdata_q[HW_W-1:0];
            end
            ST_WR_SECOND: begin
                mem_en      = 1'b1;
                mem_we      = 1'b1;
                second_half = 1'b1;
                mem_wdata   = wdata_q[DATA_W-1:HW_W];
            end
            ST_RMW_READ: begin
                mem_en = 1'b1;
            end
            ST_RMW_WRITE: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = merged_hw;
            end
            ST_DONE: begin
                req_ready = 1'b1;
            end
            default: begin
                req_ready = 1'b0;
            end
        endcase
    end

    assign mem_addr = base_idx + MEM_AW'(second_half);
    assign rsp_data = data_q;

    // R3
    rmw_same_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && state == ST_RMW_WRITE) |->
            ($past(mem_en) && !$past(mem_we) && mem_addr == $past(mem_addr)));

    // R5
    full_second_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_SECOND || state == ST_WR_SECOND) |->
            ($past(mem_en) && mem_addr == $past(mem_addr) + MEM_AW'(1)));

    // R2
    byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && size_q == SZ_BYTE) |-> (rsp_data[DATA_W-1:8] == '0));

    // R4
    half_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && size_q == SZ_HALF) |-> (rsp_data[DATA_W-1:HW_W] == '0));

endmodule

// File: rtl/memadapt_top.sv
module memadapt_top
    import memadapt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int HW_W   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [1:0]           req_size,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [2*HW_W-1:0]    req_wdata,
    output logic                 req_ready,
    output logic                 rsp_valid,
    output logic [2*HW_W-1:0]    rsp_data,
    output logic                 align_fault,
    output logic                 mem_en,
    output logic                 mem_we,
    output logic [ADDR_W-2:0]    mem_addr,
    output logic [HW_W-1:0]      mem_wdata,
    input  logic [HW_W-1:0]      mem_rdata
);

    logic       misaligned;
    logic       lane_sel;
    logic [7:0] new_byte;
    logic [7:0] byte_rd;
    logic [HW_W-1:0] merged_hw;

    memadapt_align u_align (
        .size       (req_size),
        .addr_lo    (req_addr[1:0]),
        .misaligned (misaligned)
    );

    memadapt_lane #(.HW_W(HW_W)) u_lane (
        .hw_in    (mem_rdata),
        .lane_sel (lane_sel),
        .new_byte (new_byte),
        .byte_out (byte_rd),
        .merged   (merged_hw)
    );

    memadapt_ctrl #(.ADDR_W(ADDR_W), .HW_W(HW_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_size    (req_size),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .misaligned  (misaligned),
        .byte_rd     (byte_rd),
        .merged_hw   (merged_hw),
        .mem_rdata   (mem_rdata),
        .lane_sel    (lane_sel),
        .new_byte    (new_byte),
        .req_ready   (req_ready),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .align_fault (align_fault),
        .mem_en      (mem_en),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata)
    );

    // R6
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |-> (req_ready && !mem_en && !rsp_valid));

    // R6
    fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |=> !align_fault);

    // R7
    rsp_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);

    // R7
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    // R9
    we_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);

endmodule

// File: tb/memadapt_top_tb_top.sv
module memadapt_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid, align_fault, mem_en, mem_we;
    logic [31:0] rsp_data;
    logic [14:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    memadapt_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .align_fault(align_fault), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // store model: 256 halfwords, one-cycle read latency
    logic [15:0] ram [256];
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
            else        mem_rdata <= ram[mem_addr[7:0]];
        end
    end

    // reference byte image (low byte at even address)
    logic [7:0] refm [512];

    typedef struct {
        bit          fault;
        logic [31:0] data;
        string       rq;
    } exp_t;
    exp_t exp_q[$];

    int          mem_cnt = 0;
    logic [14:0] log_addr [4];
    logic        log_we   [4];
    int          log_n = 0;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, expv);
        end
    endtask

    // monitor: store activity and scoreboard compare
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_en) begin
                if (log_n < 4) begin
                    log_addr[log_n] = mem_addr;
                    log_we[log_n]   = mem_we;
                end
                log_n++;
                mem_cnt++;
            end
            if (rsp_valid || align_fault) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected response", {30'b0, align_fault, rsp_valid}, 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(align_fault == e.fault, {e.rq, " fault flag"}, 32'(align_fault), 32'(e.fault));
                    if (!e.fault) begin
                        chk(rsp_data == e.data, {e.rq, " data"}, rsp_data, e.data);
                    end
                end
            end
        end
    end

    function automatic bit is_mis(input logic [1:0] sz, input logic [15:0] a);
        return (sz == 2'b11) || (sz == 2'b01 && a[0]) || (sz == 2'b10 && a[1:0] != 2'b00);
    endfunction

    task automatic access(input bit wr, input logic [1:0] sz, input logic [15:0] a,
                          input logic [31:0] wd, input string rq);
        int nbytes;
        int exp_cnt;
        int c0;
        bit mis;
        exp_t e;
        int ia;
        mis = is_mis(sz, a);
        nbytes = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
        ia = int'(a & 16'h01FF);
        if (mis) exp_cnt = 0;
        else if (sz == 2'b10) exp_cnt = 2;
        else if (sz == 2'b00 && wr) exp_cnt = 2;
        else exp_cnt = 1;
        e.fault = mis;
        e.rq = rq;
        e.data = '0;
        if (!mis && !wr) begin
            for (int k = 0; k < nbytes; k++) e.data[k*8 +: 8] = refm[(ia + k) & 511];
        end
        if (mis || !wr) exp_q.push_back(e);
        if (!mis && wr) begin
            for (int k = 0; k < nbytes; k++) refm[(ia + k) & 511] = wd[k*8 +: 8];
        end
        @(negedge clk);
        c0 = mem_cnt;
        log_n = 0;
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
        do @(negedge clk); while (!req_ready && !finished);
        req_valid = 1'b0;
        chk(mem_cnt - c0 == exp_cnt, {rq, " store cycle count"}, 32'(mem_cnt - c0), 32'(exp_cnt));
        if (!mis && sz == 2'b10) begin
            // R5 order: base index then base+1
            chk(log_addr[0] == a[15:1], "R5 first index", 32'(log_addr[0]), 32'(a[15:1]));
            chk(log_addr[1] == a[15:1] + 15'd1, "R5 second index", 32'(log_addr[1]), 32'(a[15:1] + 15'd1));
        end
        if (!mis && sz == 2'b00 && wr) begin
            // R3 read before write at the same index
            chk(!log_we[0] && log_we[1], "R3 read then write", {30'b0, log_we[0], log_we[1]}, 32'h1);
            chk(log_addr[0] == log_addr[1] && log_addr[0] == a[15:1], "R3 same index",
                32'(log_addr[1]), 32'(a[15:1]));
        end
        @(negedge clk);
        // R7 pulses last one cycle
        chk(!req_ready && !rsp_valid && !align_fault, "R7 pulse width",
            {29'b0, req_ready, rsp_valid, align_fault}, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            ram[i] = {8'(i * 3 + 1), 8'(i * 7 + 2)};
            refm[2*i]     = 8'(i * 7 + 2);
            refm[2*i + 1] = 8'(i * 3 + 1);
        end
        repeat (2) @(negedge clk);
        // R1 during reset
        chk(!req_ready && !rsp_valid && !align_fault && !mem_en && !mem_we, "R1 in reset",
            {27'b0, req_ready, rsp_valid, align_fault, mem_en, mem_we}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!req_ready && !rsp_valid && !align_fault && !mem_en && !mem_we, "R1 after reset",
            {27'b0, req_ready, rsp_valid, align_fault, mem_en, mem_we}, 32'h0);

        // R2 byte reads, both lanes (R8 latency exercised)
        access(0, 2'b00, 16'h0010, 32'h0, "R2 byte even");
        access(0, 2'b00, 16'h0011, 32'h0, "R2 byte odd");
        // R4 halfword read
        access(0, 2'b01, 16'h0020, 32'h0, "R4 half read");
        // R5 fullword read
        access(0, 2'b10, 16'h0040, 32'h0, "R5 full read");
        // R3 byte writes into each lane, then read back the halfword
        access(1, 2'b00, 16'h0031, 32'hFFFF_FFA5, "R3 odd lane write");
        access(0, 2'b01, 16'h0030, 32'h0, "R3 odd lane readback");
        access(1, 2'b00, 16'h0030, 32'h1234_563C, "R3 even lane write");
        access(0, 2'b01, 16'h0030, 32'h0, "R3 even lane readback");
        // R4 halfword write
        access(1, 2'b01, 16'h0050, 32'hDEAD_BEEF, "R4 half write");
        access(0, 2'b10, 16'h0050, 32'h0, "R4 half write readback");
        // R5 fullword write, read back by bytes and halves
        access(1, 2'b10, 16'h0060, 32'hCAFE_F00D, "R5 full write");
        access(0, 2'b00, 16'h0063, 32'h0, "R5 top byte");
        access(0, 2'b01, 16'h0062, 32'h0, "R5 upper half");
        // R6 misaligned requests
        access(0, 2'b01, 16'h0021, 32'h0, "R6 odd half read");
        access(1, 2'b01, 16'h0021, 32'h0000_7777, "R6 odd half write");
        access(1, 2'b10, 16'h0042, 32'h9999_9999, "R6 full addr 2");
        access(0, 2'b10, 16'h0043, 32'h0, "R6 full addr 3");
        access(1, 2'b11, 16'h0020, 32'h5555_5555, "R6 reserved size");
        // R6 stored data untouched after refused writes
        access(0, 2'b10, 16'h0020, 32'h0, "R6 untouched check");
        access(0, 2'b10, 16'h0040, 32'h0, "R6 untouched check 2");
        // boundary: top of address space and highest odd byte
        access(1, 2'b10, 16'hFFFC, 32'h0BAD_C0DE, "R5 top fullword write");
        access(0, 2'b10, 16'hFFFC, 32'h0, "R5 top fullword read");
        access(1, 2'b00, 16'hFFFF, 32'h0000_0081, "R3 last byte write");
        access(0, 2'b01, 16'hFFFE, 32'h0, "R3 last byte readback");
        access(0, 2'b00, 16'hFFFF, 32'h0, "R2 last byte");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R7 responses outstanding", 32'(exp_q.size()), 32'h0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R7 watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule